// File: doc/BRIEF.md
# Primary Clock Failure Monitor with Fail-Safe Switchover

This block watches an external primary clock against a free-running internal reference clock. It divides the reference into a slow sample clock. Each sample period holds a window in which at least one falling edge of the primary must be seen. A window with no primary edge counts as a clock failure. The block then sets a sticky flag, optionally requests an interrupt, pulses a watchdog clear for one cycle, shows through a status bit that the internal clock is running, and moves the system clock onto the reference through a glitch-free multiplexer.

Monitoring is armed only while the enable strap is high, the start-up timer has expired and the device is neither asleep nor in reset. Software leaves fail-safe by clearing the flag. The switch back to the primary happens only after a complete sample window that starts after the clear and in which primary edges are seen again.

Top module: `clk_failsafe`

## Requirements
- R1: The sample clock divides the reference by 64. Its rising and falling events alternate and lie exactly 32 reference cycles apart.
- R2: A primary clock with a falling edge at least once every 16 reference cycles never sets the fail flag.
- R3: A primary that stops at either level, or that gives fewer than one falling edge per 128 reference cycles, sets the fail flag within six sample periods.
- R4: While the strap is low, the start-up timer has not expired or the sleep/reset status is high, a dead primary never sets the fail flag.
- R5: The interrupt request is high exactly while the fail flag and the interrupt enable are both high.
- R6: Once set, the fail flag stays set until a one-cycle software clear, including after the primary recovers. A failure in the same cycle as a clear takes priority over the clear.
- R7: In fail-safe, the system clock carries every reference clock edge. Outside fail-safe, it carries every primary clock edge.
- R8: The oscillator-status bit is 0 in fail-safe. Outside fail-safe it follows the start-up-timer-expired input.
- R9: Each entry into fail-safe gives exactly one watchdog-clear pulse, one reference cycle wide. A detection that repeats while already in fail-safe gives no pulse.
- R10: Fail-safe is left only after the flag is clear and a full sample window that starts after the clear has seen primary edges. If the primary is still dead, the block stays in fail-safe and the flag is set again.
- R11: The primary and reference clock enables of the multiplexer are never high at the same time.
- R12: After reset, the fail flag, interrupt request and watchdog-clear pulse are 0, and the block is not in fail-safe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | External primary clock under watch |
| ref_clk | input | 1 | Internal free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_strap | input | 1 | Monitor enable strap |
| ost_done | input | 1 | Start-up timer has expired |
| sleep_rst | input | 1 | Device is in sleep or reset |
| irq_en | input | 1 | Interrupt enable for the fail flag |
| sw_clr | input | 1 | One-cycle software clear of the fail flag (reference domain) |
| sys_clk | output | 1 | Selected system clock |
| fail_flag | output | 1 | Sticky oscillator-failure flag |
| irq | output | 1 | Interrupt request |
| osc_stat | output | 1 | 1 while the primary is the running clock |
| wdt_clr | output | 1 | One-cycle watchdog clear on entry to fail-safe |

## Verification
The assertions check on every reference cycle that the sample events are spaced correctly, that the flag stays sticky, that the flag implies fail-safe, that the interrupt follows its enable, that gated monitoring cannot raise the flag, that the watchdog clear is one cycle wide and that the two clock enables never overlap. Only the bench scenarios can show the detection thresholds for stopped, slow and borderline-fast primaries. They also show the recovery sequence after a clear, the case of a clear while the primary is still dead, and that the system clock really carries the edges of the right source.

// File: rtl/clk_failsafe_pkg.sv
package clk_failsafe_pkg;

  // Index of the last count in the first half of the sample period.
  function automatic int unsigned half_last(input int unsigned div_log2);
    return (1 << (div_log2 - 1)) - 1;
  endfunction

  // Index of the last count in the whole sample period.
  function automatic int unsigned full_last(input int unsigned div_log2);
    return (1 << div_log2) - 1;
  endfunction

  // Number of reference cycles between a rising and a falling sample event.
  function automatic int unsigned event_gap(input int unsigned div_log2);
    return 1 << (div_log2 - 1);
  endfunction

endpackage

// File: rtl/fscm_sync.sv
module fscm_sync #(
  parameter int STAGES   = 2,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end else begin : g_pos
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fscm_sampler.sv
module fscm_sampler
  import clk_failsafe_pkg::*;
#(
  parameter int DIV_LOG2    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_on,
  output logic rise_ev,
  output logic fall_ev,
  output logic seen,
  output logic miss_ev,
  output logic ok_ev
);
  localparam logic [DIV_LOG2-1:0] RISE_AT = DIV_LOG2'(half_last(DIV_LOG2));
  localparam logic [DIV_LOG2-1:0] FALL_AT = DIV_LOG2'(full_last(DIV_LOG2));

  logic [DIV_LOG2-1:0] div_cnt;
  logic pri_tog, tog_sync, tog_prev, pri_edge, mon_arm;

  // A toggle in the primary domain marks every falling primary edge.
  always_ff @(negedge pri_clk or negedge rst_n) begin
    if (!rst_n) pri_tog <= 1'b0;
    else        pri_tog <= ~pri_tog;
  end

  fscm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_tog_sync (
    .clk(ref_clk), .clr_n(rst_n), .d(pri_tog), .q(tog_sync)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tog_prev <= 1'b0;
    else        tog_prev <= tog_sync;
  end
  assign pri_edge = tog_sync ^ tog_prev;

  // Divider: rising event at the middle, falling event at wrap.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end
  assign rise_ev = (div_cnt == RISE_AT);
  assign fall_ev = (div_cnt == FALL_AT);

  // Monitoring latch: cleared by the sample rise, set by primary edges.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)        seen <= 1'b0;
    else if (rise_ev)  seen <= 1'b0;
    else if (pri_edge) seen <= 1'b1;
  end

  // A window counts only if monitoring was on for all of it.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)       mon_arm <= 1'b0;
    else if (!mon_on) mon_arm <= 1'b0;
    else if (rise_ev) mon_arm <= 1'b1;
  end

  assign miss_ev = fall_ev & mon_on & mon_arm & ~seen;
  assign ok_ev   = fall_ev & mon_on & mon_arm &  seen;
endmodule

// File: rtl/fscm_ctrl.sv
module fscm_ctrl (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic miss_ev,
  input  logic ok_ev,
  input  logic sw_clr,
  output logic fail_flag,
  output logic fs_active,
  output logic wdt_clr
);
  logic win_clean;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)       fail_flag <= 1'b0;
    else if (miss_ev) fail_flag <= 1'b1;
    else if (sw_clr)  fail_flag <= 1'b0;
  end

  // The window must start after the flag has been cleared.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)         win_clean <= 1'b0;
    else if (fail_flag) win_clean <= 1'b0;
    else if (rise_ev)   win_clean <= 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                                fs_active <= 1'b0;
    else if (miss_ev)                          fs_active <= 1'b1;
    else if (ok_ev && win_clean && !fail_flag) fs_active <= 1'b0;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) wdt_clr <= 1'b0;
    else        wdt_clr <= miss_ev & ~fs_active;
  end
endmodule

// File: rtl/fscm_clk_mux.sv
module fscm_clk_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic sel_ref,
  output logic en_pri,
  output logic en_int,
  output logic sys_clk
);
  logic pri_clr_n, pri_req, int_req;

  // A dead primary cannot clock its own enable low, so fail-safe clears it at once.
  assign pri_clr_n = rst_n & ~sel_ref;
  assign pri_req   = ~sel_ref & ~en_int;
  assign int_req   =  sel_ref & ~en_pri;

  fscm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_pri_en (
    .clk(pri_clk), .clr_n(pri_clr_n), .d(pri_req), .q(en_pri)
  );

  fscm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_int_en (
    .clk(ref_clk), .clr_n(rst_n), .d(int_req), .q(en_int)
  );

  assign sys_clk = (pri_clk & en_pri) | (ref_clk & en_int);
endmodule

// File: rtl/clk_failsafe.sv
module clk_failsafe #(
  parameter int DIV_LOG2    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic pri_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic en_strap,
  input  logic ost_done,
  input  logic sleep_rst,
  input  logic irq_en,
  input  logic sw_clr,
  output logic sys_clk,
  output logic fail_flag,
  output logic irq,
  output logic osc_stat,
  output logic wdt_clr
);
  logic mon_on, rise_ev, fall_ev, seen, miss_ev, ok_ev;
  logic fs_active, en_pri, en_int;

  assign mon_on = en_strap & ost_done & ~sleep_rst;

  fscm_sampler #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .pri_clk(pri_clk), .ref_clk(ref_clk), .rst_n(rst_n), .mon_on(mon_on),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .seen(seen),
    .miss_ev(miss_ev), .ok_ev(ok_ev)
  );

  fscm_ctrl u_ctrl (
    .ref_clk(ref_clk), .rst_n(rst_n), .rise_ev(rise_ev), .miss_ev(miss_ev),
    .ok_ev(ok_ev), .sw_clr(sw_clr), .fail_flag(fail_flag),
    .fs_active(fs_active), .wdt_clr(wdt_clr)
  );

  fscm_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .pri_clk(pri_clk), .ref_clk(ref_clk), .rst_n(rst_n), .sel_ref(fs_active),
    .en_pri(en_pri), .en_int(en_int), .sys_clk(sys_clk)
  );

  assign irq      = fail_flag & irq_en;
  assign osc_stat = ost_done & ~fs_active;
endmodule

// File: rtl/clk_failsafe_checks.sv
module clk_failsafe_checks
  import clk_failsafe_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input logic ref_clk,
  input logic rst_n,
  input logic en_strap,
  input logic ost_done,
  input logic sleep_rst,
  input logic irq_en,
  input logic sw_clr,
  input logic fail_flag,
  input logic irq,
  input logic osc_stat,
  input logic wdt_clr,
  input logic rise_ev,
  input logic fall_ev,
  input logic miss_ev,
  input logic fs_active,
  input logic en_pri,
  input logic en_int
);
  localparam int GAP = event_gap(DIV_LOG2);

  logic [DIV_LOG2:0] since_ev;
  logic started, last_rise;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ev  <= '0;
      started   <= 1'b0;
      last_rise <= 1'b0;
    end else if (rise_ev || fall_ev) begin
      since_ev  <= '0;
      started   <= 1'b1;
      last_rise <= rise_ev;
    end else begin
      since_ev  <= since_ev + 1'b1;
    end
  end

  p_event_gap_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (started && (rise_ev || fall_ev)) |-> (since_ev == (DIV_LOG2+1)'(GAP - 1)));

  p_event_alternate_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (started && rise_ev) |-> !last_rise);

  p_gated_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((!en_strap || !ost_done || sleep_rst) && !fail_flag) |=> !fail_flag);

  p_irq_needs_en_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq |-> irq_en);

  p_irq_needs_flag_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !fail_flag |-> !irq);

  p_flag_sticky_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_flag && !sw_clr) |=> fail_flag);

  p_miss_wins_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    miss_ev |=> fail_flag);

  p_status_low_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    miss_ev |=> !osc_stat);

  p_wdt_pulse_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr);

  p_flag_in_fs_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_flag |-> fs_active);

  p_no_overlap_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(en_pri && en_int));
endmodule

bind clk_failsafe clk_failsafe_checks #(.DIV_LOG2(DIV_LOG2)) u_checks (
  .ref_clk(ref_clk), .rst_n(rst_n), .en_strap(en_strap), .ost_done(ost_done),
  .sleep_rst(sleep_rst), .irq_en(irq_en), .sw_clr(sw_clr),
  .fail_flag(fail_flag), .irq(irq), .osc_stat(osc_stat), .wdt_clr(wdt_clr),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .miss_ev(miss_ev),
  .fs_active(fs_active), .en_pri(en_pri), .en_int(en_int)
);

// File: tb/clk_failsafe_test.sv
`timescale 1ns/1ps
module clk_failsafe_test;
  localparam int PER = 64;

  logic ref_clk = 1'b0, pri_clk = 1'b0, rst_n = 1'b0;
  logic en_strap = 1'b0, ost_done = 1'b0, sleep_rst = 1'b0, irq_en = 1'b0, sw_clr = 1'b0;
  logic sys_clk, fail_flag, irq, osc_stat, wdt_clr;
  logic pri_run = 1'b1, pri_hold = 1'b0;
  int   pri_half = 10;
  int   checks = 0, errors = 0;
  int   n_sys = 0, n_ref = 0, n_pri = 0, n_wdt = 0;

  clk_failsafe uut (
    .pri_clk(pri_clk), .ref_clk(ref_clk), .rst_n(rst_n), .en_strap(en_strap),
    .ost_done(ost_done), .sleep_rst(sleep_rst), .irq_en(irq_en), .sw_clr(sw_clr),
    .sys_clk(sys_clk), .fail_flag(fail_flag), .irq(irq), .osc_stat(osc_stat),
    .wdt_clr(wdt_clr)
  );

  always #2 ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (pri_run) begin
        #(pri_half * 1ns) pri_clk = ~pri_clk;
      end else begin
        pri_clk = pri_hold;
        #4;
      end
    end
  end

  always @(posedge sys_clk) n_sys++;
  always @(posedge ref_clk) n_ref++;
  always @(posedge pri_clk) n_pri++;
  always @(negedge ref_clk) if (wdt_clr) n_wdt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulse_clear();
    sw_clr = 1'b1;
    wait_cyc(1);
    sw_clr = 1'b0;
  endtask

  // R7: compare system clock edges with the expected source over a window.
  task automatic check_source(input bit from_ref, input string req);
    int s0, r0, p0, ds, dx;
    s0 = n_sys; r0 = n_ref; p0 = n_pri;
    wait_cyc(200);
    ds = n_sys - s0;
    dx = from_ref ? (n_ref - r0) : (n_pri - p0);
    check(ds >= dx - 1 && ds <= dx + 1, req, ds, dx);
  endtask

  task automatic t_reset();
    wait_cyc(3);
    check(fail_flag == 1'b0, "R12 flag", fail_flag, 0);
    check(irq == 1'b0, "R12 irq", irq, 0);
    check(wdt_clr == 1'b0, "R12 wdt", wdt_clr, 0);
    check(osc_stat == 1'b0, "R12/R8 status follows timer", osc_stat, 0);
  endtask

  task automatic t_healthy();
    en_strap = 1'b1; ost_done = 1'b1; pri_run = 1'b1; pri_half = 10;
    wait_cyc(20 * PER);
    check(fail_flag == 1'b0, "R2 healthy no fail", fail_flag, 0);
    check(osc_stat == 1'b1, "R8 status on primary", osc_stat, 1);
    check_source(1'b0, "R7 sys follows primary");
  endtask

  task automatic t_boundary_fast();
    pri_half = 32;
    wait_cyc(20 * PER);
    check(fail_flag == 1'b0, "R2 edge every 16 cycles", fail_flag, 0);
    pri_half = 10;
    wait_cyc(2 * PER);
  endtask

  task automatic t_gated();
    en_strap = 1'b0; pri_run = 1'b0; pri_hold = 1'b0;
    wait_cyc(8 * PER);
    check(fail_flag == 1'b0, "R4 strap low", fail_flag, 0);
    en_strap = 1'b1; ost_done = 1'b0;
    wait_cyc(8 * PER);
    check(fail_flag == 1'b0, "R4 timer not expired", fail_flag, 0);
    ost_done = 1'b1; sleep_rst = 1'b1;
    wait_cyc(8 * PER);
    check(fail_flag == 1'b0, "R4 sleep", fail_flag, 0);
    check(n_wdt == 0, "R4 no watchdog clear", n_wdt, 0);
    pri_run = 1'b1;
    wait_cyc(PER);
    sleep_rst = 1'b0;
    wait_cyc(4 * PER);
    check(fail_flag == 1'b0, "R2 resumed monitoring", fail_flag, 0);
  endtask

  task automatic t_fail_stop();
    irq_en = 1'b0; pri_run = 1'b0; pri_hold = 1'b0;
    wait_cyc(6 * PER);
    check(fail_flag == 1'b1, "R3 stopped low", fail_flag, 1);
    check(irq == 1'b0, "R5 irq masked", irq, 0);
    check(osc_stat == 1'b0, "R8 status in fail-safe", osc_stat, 0);
    check(n_wdt == 1, "R9 one watchdog pulse", n_wdt, 1);
    check_source(1'b1, "R7 sys follows reference");
    irq_en = 1'b1;
    wait_cyc(2);
    check(irq == 1'b1, "R5 irq enabled", irq, 1);
  endtask

  task automatic t_sticky_recover();
    pri_run = 1'b1; pri_half = 10;
    wait_cyc(6 * PER);
    check(fail_flag == 1'b1, "R6 sticky after recovery", fail_flag, 1);
    check(osc_stat == 1'b0, "R10 no exit without clear", osc_stat, 0);
    pulse_clear();
    wait_cyc(2);
    check(fail_flag == 1'b0, "R6 cleared by software", fail_flag, 0);
    check(irq == 1'b0, "R5 irq drops with flag", irq, 0);
    wait_cyc(4 * PER);
    check(osc_stat == 1'b1, "R10 exit after clean window", osc_stat, 1);
    check_source(1'b0, "R7 sys back on primary");
    check(n_wdt == 1, "R9 no pulse on exit", n_wdt, 1);
  endtask

  task automatic t_clear_while_dead();
    pri_run = 1'b0; pri_hold = 1'b1;
    wait_cyc(6 * PER);
    check(fail_flag == 1'b1, "R3 stopped high", fail_flag, 1);
    check(n_wdt == 2, "R9 second entry pulse", n_wdt, 2);
    pulse_clear();
    wait_cyc(6 * PER);
    check(osc_stat == 1'b0, "R10 stays while dead", osc_stat, 0);
    check(fail_flag == 1'b1, "R10 flag set again", fail_flag, 1);
    check(n_wdt == 2, "R9 no pulse on repeat", n_wdt, 2);
    pri_run = 1'b1;
    wait_cyc(2 * PER);
    pulse_clear();
    wait_cyc(4 * PER);
    check(osc_stat == 1'b1, "R10 exit after restart", osc_stat, 1);
  endtask

  task automatic t_slow();
    pri_half = 400;
    wait_cyc(6 * PER);
    check(fail_flag == 1'b1, "R3 slow primary", fail_flag, 1);
    check(n_wdt == 3, "R9 third entry pulse", n_wdt, 3);
    pri_half = 10;
    wait_cyc(2 * PER);
    pulse_clear();
    wait_cyc(4 * PER);
    check(fail_flag == 1'b0, "R6 cleared after slow", fail_flag, 0);
    check(osc_stat == 1'b1, "R10 exit after slow", osc_stat, 1);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    t_reset();
    t_healthy();
    t_boundary_fast();
    t_gated();
    t_fail_stop();
    t_sticky_recover();
    t_clear_while_dead();
    t_slow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule